// File: doc/BRIEF.md
# Ring Indicator Pulse-Train Filter

This block conditions three active-low ring-indicate pins before they reach the wake and interrupt logic. Each channel runs in one of two modes, and a bit in a small control register picks the mode. In edge mode, every high-to-low transition of the pin produces a short active-low indication. In train mode, the channel first has to see a sustained ring cadence. Falling edges must keep arriving with no gap longer than a period limit, and this must go on for a qualifying window. Only then does the indication go low. Its falling edge is the ring trigger.

The block works from a slow tick enable, nominally one per millisecond. All pin sampling, interval measurement and window counting advance on that tick. Each pin first passes through a two-flop synchroniser that runs on the fast clock. The period limit (about 66.7 ms, which is 15 Hz) and the qualifying window (200 ms) are given in ticks as parameters. A bench can therefore use small counts.

Top module: `ring_cadence_filter`

## Requirements
- R1: After reset the control register reads 0x00 and all three indication outputs are high.
- R2: A write stores data bits 2:0 as the channel mode bits. Reads return those bits in positions 2:0, and bits 7:3 always read 0 whatever was written.
- R3: Mode bit 0 controls channel 0 (the combined ring pin), bit 1 controls channel 1 (first ring input) and bit 2 controls channel 2 (second ring input). A bit of 1 selects train mode and 0 selects edge mode.
- R4: In edge mode, a tick that samples the pin low, when the previous tick sampled it high, drives the indication low. It stays low until the next tick, which is exactly one tick period.
- R5: In edge mode, rising edges and steady levels drive the indication high at the next tick.
- R6: In train mode, a falling edge that starts a train drives the indication low at the tick that lies QUAL_TICKS ticks after the starting edge. This holds as long as every interval between successive falling edges is at most PERIOD_TICKS ticks.
- R7: In train mode, a falling edge that comes more than PERIOD_TICKS ticks after the previous one (or after an idle pin) starts a fresh train. Qualification then restarts from that edge.
- R8: In train mode, a qualified indication stays low while edges keep meeting the period limit. It returns high at the tick that lies PERIOD_TICKS ticks after the last falling edge, if no new edge has come.
- R9: The channels are independent. Each one follows only its own pin and its own mode bit.
- R10: Without a tick enable, the outputs and all channel state hold still, whatever the pins do.
- R11: Clearing a mode bit in the middle of a train drops that train. From the next tick the channel behaves as in edge mode, and the train has to qualify again from scratch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle sampling strobe; all timing counts in these |
| ring_n | input | 3 | Asynchronous active-low ring pins, index = channel |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| ind_n | output | 3 | Active-low ring indications, index = channel |

## Verification
The bench sweeps the ring period across the period limit, taking values just below it, at it, and one and two ticks past it. A filter with an off-by-one in the gap compare would qualify a train that is too slow, or drop one that sits exactly at the limit. Qualification onset is checked tick by tick, so a design that counts the window from the wrong edge would assert one tick early or late. Release timing after the last edge is checked the same way. The bench also writes mixed mode words so that a swapped bit-to-channel mapping becomes visible. It clears the mode during a qualified train, which would leave a stuck-low indication in a design that kept train state. It toggles the pins with no tick, which would move a design that samples on every clock.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    // Channel conditioning mode as held in the control register.
    typedef enum logic {
        RCF_EDGE  = 1'b0,
        RCF_TRAIN = 1'b1
    } rcf_mode_e;

    localparam int unsigned RCF_REG_W = 8;

endpackage

// File: rtl/rcf_sync.sv
module rcf_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.meta   = async_in;
        s_d.stable = s_q.meta;
    end

    // Idle pin level is high, so reset to ones to avoid a false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{meta: '1, stable: '1};
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_out = s_q.stable;

endmodule

// File: rtl/rcf_ctrl.sv
module rcf_ctrl
    import rcf_pkg::*;
#(
    parameter int unsigned CH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [RCF_REG_W-1:0] wr_data,
    output logic [RCF_REG_W-1:0] rd_data,
    output logic [CH-1:0]        mode
);

    localparam int unsigned PAD_W = RCF_REG_W - CH;

    typedef struct packed {
        logic [CH-1:0] mode;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (wr_en) begin
            c_d.mode = wr_data[CH-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '{mode: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign mode    = c_q.mode;
    assign rd_data = {{PAD_W{1'b0}}, c_q.mode};

endmodule

// File: rtl/rcf_channel.sv
module rcf_channel
    import rcf_pkg::*;
#(
    parameter int unsigned PERIOD_TICKS = 67,
    parameter int unsigned QUAL_TICKS   = 200
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_en,
    input  rcf_mode_e mode,
    input  logic      pin_lvl,
    output logic      ind_n
);

    localparam int unsigned GAP_W  = $clog2(PERIOD_TICKS + 2);
    localparam int unsigned QUAL_W = $clog2(QUAL_TICKS + 1);
    localparam logic [GAP_W-1:0]  GAP_LIM  = GAP_W'(PERIOD_TICKS);
    localparam logic [QUAL_W-1:0] QUAL_LIM = QUAL_W'(QUAL_TICKS);

    typedef struct packed {
        logic              prev;      // pin level at the previous tick
        logic              tracking;  // a train is in progress
        logic [GAP_W-1:0]  gap;       // ticks since the last falling edge
        logic [QUAL_W-1:0] qual;      // ticks since the train started
        logic              low;       // indication asserted
    } chan_t;

    chan_t ch_d, ch_q;
    logic  fall;
    logic [QUAL_W-1:0] qual_inc;

    always_comb begin
        fall     = ch_q.prev & ~pin_lvl;
        qual_inc = (ch_q.qual < QUAL_LIM) ? ch_q.qual + 1'b1 : ch_q.qual;
        ch_d     = ch_q;

        if (tick_en) begin
            ch_d.prev = pin_lvl;
            if (mode == RCF_EDGE) begin
                ch_d.tracking = 1'b0;
                ch_d.gap      = '0;
                ch_d.qual     = '0;
                ch_d.low      = fall;
            end else begin
                if (fall) begin
                    ch_d.tracking = 1'b1;
                    ch_d.gap      = GAP_W'(1);
                    ch_d.qual     = ch_q.tracking ? qual_inc : '0;
                end else if (ch_q.tracking) begin
                    if (ch_q.gap >= GAP_LIM) begin
                        ch_d.tracking = 1'b0;
                        ch_d.gap      = '0;
                        ch_d.qual     = '0;
                    end else begin
                        ch_d.gap  = ch_q.gap + 1'b1;
                        ch_d.qual = qual_inc;
                    end
                end
                ch_d.low = ch_d.tracking && (ch_d.qual == QUAL_LIM);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '{prev: 1'b1, tracking: 1'b0, gap: '0, qual: '0, low: 1'b0};
        end else begin
            ch_q <= ch_d;
        end
    end

    assign ind_n = ~ch_q.low;

endmodule

// File: rtl/ring_cadence_filter.sv
module ring_cadence_filter
    import rcf_pkg::*;
#(
    parameter int unsigned CH           = 3,
    parameter int unsigned PERIOD_TICKS = 67,
    parameter int unsigned QUAL_TICKS   = 200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [CH-1:0] ring_n,
    input  logic          reg_we,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic [CH-1:0] ind_n
);

    logic [CH-1:0] mode_q;
    logic [CH-1:0] pin_sync;

    rcf_sync #(.W(CH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ring_n),
        .sync_out (pin_sync)
    );

    rcf_ctrl #(.CH(CH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_data (reg_wdata),
        .rd_data (reg_rdata),
        .mode    (mode_q)
    );

    for (genvar g = 0; g < CH; g++) begin : g_chan
        rcf_channel #(
            .PERIOD_TICKS (PERIOD_TICKS),
            .QUAL_TICKS   (QUAL_TICKS)
        ) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .mode    (rcf_mode_e'(mode_q[g])),
            .pin_lvl (pin_sync[g]),
            .ind_n   (ind_n[g])
        );
    end

endmodule

// File: rtl/rcf_checker.sv
module rcf_checker #(
    parameter int unsigned CH = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_en,
    input logic [CH-1:0] mode_q,
    input logic [CH-1:0] pin_sync,
    input logic [CH-1:0] ind_n,
    input logic [7:0]    reg_rdata
);

    // R1: a reset cycle leaves outputs idle and the register cleared
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (ind_n == '1) && (reg_rdata == 8'h00));

    // R2: reserved bits never read back as ones
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:CH] == '0);

    // R10: no tick, no movement on the indications
    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(ind_n));

    for (genvar g = 0; g < CH; g++) begin : g_chk
        // R5: edge mode with a high sampled pin releases the indication
        a_r5_edge_high_pin: assert property (@(posedge clk) disable iff (!rst_n)
            tick_en && !mode_q[g] && pin_sync[g] |=> ind_n[g]);

        // R4: edge mode indication only falls on a tick that saw the pin low
        a_r4_edge_fall_on_low: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ind_n[g]) && !$past(mode_q[g]) |-> $past(tick_en) && !$past(pin_sync[g]));
    end

endmodule

bind ring_cadence_filter rcf_checker #(.CH(CH)) u_rcf_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .mode_q    (mode_q),
    .pin_sync  (pin_sync),
    .ind_n     (ind_n),
    .reg_rdata (reg_rdata)
);

// File: tb/test_ring_cadence_filter.sv
module test_ring_cadence_filter;

    localparam int CH     = 3;
    localparam int PERIOD = 4;
    localparam int QUAL   = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [CH-1:0] ring_n = '1;
    logic          reg_we = 1'b0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [CH-1:0] ind_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side expectation, per channel
    logic [CH-1:0] m_mode;
    bit m_prev [CH];
    bit m_trk  [CH];
    int m_gap  [CH];
    int m_qual [CH];
    bit m_low  [CH];

    always #4 clk = ~clk;

    ring_cadence_filter #(
        .CH(CH), .PERIOD_TICKS(PERIOD), .QUAL_TICKS(QUAL)
    ) i_ring_cadence_filter (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ring_n(ring_n),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ind_n(ind_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_mode = '0;
        for (int c = 0; c < CH; c++) begin
            m_prev[c] = 1; m_trk[c] = 0; m_gap[c] = 0; m_qual[c] = 0; m_low[c] = 0;
        end
    endtask

    task automatic model_tick(input logic [CH-1:0] pins);
        for (int c = 0; c < CH; c++) begin
            bit f;
            f = m_prev[c] && !pins[c];
            m_prev[c] = pins[c];
            if (!m_mode[c]) begin
                m_trk[c] = 0; m_gap[c] = 0; m_qual[c] = 0; m_low[c] = f;
            end else begin
                if (f) begin
                    m_qual[c] = m_trk[c] ? ((m_qual[c] < QUAL) ? m_qual[c] + 1 : QUAL) : 0;
                    m_trk[c] = 1; m_gap[c] = 1;
                end else if (m_trk[c]) begin
                    if (m_gap[c] + 1 > PERIOD) begin
                        m_trk[c] = 0; m_gap[c] = 0; m_qual[c] = 0;
                    end else begin
                        m_gap[c]++;
                        m_qual[c] = (m_qual[c] < QUAL) ? m_qual[c] + 1 : QUAL;
                    end
                end
                m_low[c] = m_trk[c] && (m_qual[c] == QUAL);
            end
        end
    endtask

    function automatic logic [CH-1:0] expected_ind();
        logic [CH-1:0] e;
        for (int c = 0; c < CH; c++) e[c] = !m_low[c];
        return e;
    endfunction

    // one tick: drive pins, let them settle through the synchroniser, strobe, compare
    task automatic step(input logic [CH-1:0] pins, input string req);
        ring_n = pins;
        repeat (3) @(posedge clk);
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        model_tick(pins);
        check(req, ind_n, expected_ind());
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
        m_mode = v[CH-1:0];
    endtask

    function automatic logic pin_of(input int per, input int t);
        return ((t % per) < ((per > 1) ? per / 2 : 1)) ? 1'b0 : 1'b1;
    endfunction

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 ind", ind_n, 3'b111);

        // R2: register storage and reserved bits
        write_reg(8'hFF); check("R2 ff", reg_rdata, 8'h07);
        write_reg(8'hA5); check("R2 a5", reg_rdata, 8'h05);
        write_reg(8'h5A); check("R2 5a", reg_rdata, 8'h02);
        write_reg(8'h00); check("R2 00", reg_rdata, 8'h00);

        // R4 / R5: edge mode on three cadences, plus a held-low stretch
        for (int t = 0; t < 40; t++) begin
            logic [CH-1:0] p;
            p = {pin_of(5, t), pin_of(3, t), pin_of(2, t)};
            step(p, (p == 3'b111) ? "R5" : "R4");
        end
        for (int t = 0; t < 6; t++) step(3'b000, "R5 held low");
        for (int t = 0; t < 3; t++) step(3'b111, "R5 rising");

        // R10: pins toggle without a tick
        for (int k = 0; k < 20; k++) begin
            @(negedge clk) ring_n = k[0] ? 3'b000 : 3'b111;
            check("R10", ind_n, expected_ind());
        end
        ring_n = 3'b111;
        repeat (4) @(posedge clk);

        // R6 / R7 / R8: period sweep across the limit in train mode
        write_reg(8'h07);
        for (int k = 2; k <= PERIOD + 2; k++) begin
            for (int t = 0; t < 3 * QUAL; t++) begin
                step({pin_of(PERIOD + 1, t), pin_of(PERIOD, t), pin_of(k, t)},
                     (k <= PERIOD) ? "R6" : "R7");
            end
            for (int t = 0; t < PERIOD + 3; t++) step(3'b111, "R8");
        end

        // R3: only channel 0 filters
        write_reg(8'h01);
        for (int t = 0; t < 2 * QUAL; t++) step({3{pin_of(2, t)}}, "R3");
        for (int t = 0; t < PERIOD + 2; t++) step(3'b111, "R3 idle");

        // R9: mixed modes, separate cadences
        write_reg(8'h02);
        for (int t = 0; t < 2 * QUAL; t++)
            step({pin_of(3, t), pin_of(3, t), pin_of(7, t)}, "R9");
        for (int t = 0; t < PERIOD + 2; t++) step(3'b111, "R9 idle");

        // R11: drop the mode during a qualified train, then restore it
        write_reg(8'h07);
        for (int t = 0; t < QUAL + 4; t++) step({3{pin_of(2, t)}}, "R11 qualify");
        check("R11 qualified", ind_n, 3'b000);
        write_reg(8'h00);
        for (int t = 0; t < 8; t++) step({3{pin_of(2, t)}}, "R11 edge");
        write_reg(8'h07);
        for (int t = 0; t < QUAL + 3; t++) step({3{pin_of(2, t)}}, "R11 requalify");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule